// File: doc/BRIEF.md
# USB 2.0 PHY Bring-Up Sequencer

This block replaces a software routine that would otherwise bring a USB 2.0 PHY out of reset. After a `start` pulse it holds the PHY in reset for a timed interval, then releases it. It puts the port into its clamped, frozen and powered-down condition and saves the reset value of the PLL test register. It writes a fixed list of tuning values and merges a fused trim nibble into one tuning register. It then takes the port out of power-down and waits for it to settle. Next it selects the reference-clock scheme by rewriting the saved PLL test value, and after a second settle interval it checks the PLL lock flag. A locked PLL ends the run with a one-cycle `done`. An unlocked PLL puts the PHY back into reset and raises a sticky `error`.

All register traffic goes through a simple master port with a valid/ready handshake, and only one access is outstanding at a time. An exit request, taken once the PHY is running, powers the port down again, stops the reference clock and asserts the PHY reset. The settle intervals are given in microseconds and converted to clock cycles through the `CLKS_PER_US` parameter.

Top module: `phy_init_seq`

## Requirements
- R1: After an accepted `start`, `phyRst` stays high for at least `RST_US*CLKS_PER_US` cycles. No register access is issued while `phyRst` is high.
- R2: The first two accesses read offset 0xB4 and then write the read value back with bits 5, 1 and 0 set (mask 0x23).
- R3: The third access reads offset 0x04. The value read is kept for the clock-scheme rewrite in R7.
- R4: The tuning writes follow, in this order: 0x80←F8, 0x84←B3, 0x88←83, 0x8C←C0, 0x08←30, 0x0C←79, 0x10←21, 0x9C←14, 0x1C←9F, 0x18←00.
- R5: When `trimValid` is 1 and `trimByte` is nonzero at `start`, the sequencer reads 0x84 and writes back the read value ORed with `trimByte<<4`, truncated to 8 bits. Otherwise neither access takes place.
- R6: The sequencer then reads 0xB4 and writes back the read value with only bit 0 cleared. At least `PWR_US*CLKS_PER_US` cycles pass between that write and the next access.
- R7: The sequencer writes the saved 0x04 value to 0x04 and reads 0x04 back. With `clkSchemeSel`=1 (single-ended) bit 7 is set and `refClkEn` stays low. With `clkSchemeSel`=0 (differential) bit 7 is cleared and `refClkEn` is high from that write onward. At least `LOCK_US*CLKS_PER_US` cycles pass between the read-back and the next access.
- R8: The last access reads 0x38. If bit 5 is set, `done` pulses for exactly one cycle and `phyRst` stays low. If bit 5 is clear, `error` rises, `refClkEn` goes low, `phyRst` goes high and `done` stays low.
- R9: With the PHY running, an `exitReq` pulse reads 0xB4 and writes the read value back with mask 0x23 set. The sequencer then drives `refClkEn` low and `phyRst` high and returns to idle.
- R10: A `start` that arrives while `busy` is high has no effect on the access sequence. `error` holds until the next accepted `start`, which clears it.
- R11: While `regValid` is high and `regReady` is low, `regValid`, `regAddr`, `regWrite` and `regWdata` hold their values.
- R12: While `rstN` is low and just after it is released, `phyRst` is 1 and `refClkEn`, `busy`, `done`, `error` and `regValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin bring-up (taken only when idle) |
| exitReq | input | 1 | Shut the running PHY down |
| trimByte | input | 8 | Fused trim value |
| trimValid | input | 1 | Trim value is usable |
| clkSchemeSel | input | 1 | 1 = single-ended reference, 0 = differential |
| regValid | output | 1 | Register access request |
| regWrite | output | 1 | 1 = write, 0 = read |
| regAddr | output | 8 | Register offset |
| regWdata | output | 8 | Write data |
| regReady | input | 1 | Access accepted this cycle |
| regRdata | input | 8 | Read data, valid with regReady |
| phyRst | output | 1 | PHY reset, active high |
| refClkEn | output | 1 | Differential reference clock enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | PLL lock failure, sticky |

## Verification
The sequence is run with the clock-scheme input at both values, and the trim input in three forms: valid and nonzero, valid and zero, and invalid. Comparing the recorded access list against a model built from these cases tells apart a merge that always happens, one that never happens, and one that keeps the upper trim bits. The lock flag is driven both set and clear to separate the success path from the error path. The saved 0x04 and 0xB4 reset values are randomized, so a read-modify-write that ignores the value read shows up as a data mismatch. A random ready delay stresses the handshake hold, and a `start` issued mid-run shows whether a busy restart is rejected.

// File: rtl/phy_init_pkg.sv
package phy_init_pkg;

  localparam logic [7:0] ADDR_PWRDN   = 8'hB4;
  localparam logic [7:0] ADDR_PLLTEST = 8'h04;
  localparam logic [7:0] ADDR_TUNE2   = 8'h84;
  localparam logic [7:0] ADDR_PLLSTAT = 8'h38;

  localparam logic [7:0] PWRDN_ALL  = 8'h23;  // clamp, freeze, power-down
  localparam int         BIT_PD     = 0;
  localparam int         BIT_REFSEL = 7;
  localparam int         BIT_LOCK   = 5;

  localparam int TBL_LEN = 10;
  localparam int TBL_IW  = $clog2(TBL_LEN);

  function automatic logic [7:0] tblAddr(input logic [TBL_IW-1:0] i);
    case (i)
      4'd0: tblAddr = 8'h80;
      4'd1: tblAddr = 8'h84;
      4'd2: tblAddr = 8'h88;
      4'd3: tblAddr = 8'h8C;
      4'd4: tblAddr = 8'h08;
      4'd5: tblAddr = 8'h0C;
      4'd6: tblAddr = 8'h10;
      4'd7: tblAddr = 8'h9C;
      4'd8: tblAddr = 8'h1C;
      4'd9: tblAddr = 8'h18;
      default: tblAddr = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] tblData(input logic [TBL_IW-1:0] i);
    case (i)
      4'd0: tblData = 8'hF8;
      4'd1: tblData = 8'hB3;
      4'd2: tblData = 8'h83;
      4'd3: tblData = 8'hC0;
      4'd4: tblData = 8'h30;
      4'd5: tblData = 8'h79;
      4'd6: tblData = 8'h21;
      4'd7: tblData = 8'h14;
      4'd8: tblData = 8'h9F;
      default: tblData = 8'h00;
    endcase
  endfunction

  typedef enum logic [3:0] {
    BUS_PD_RD, BUS_PD_SET, BUS_TEST_RD, BUS_TBL, BUS_TRIM_RD,
    BUS_TRIM_WR, BUS_PD_CLR, BUS_REF_WR, BUS_REF_RD, BUS_STAT_RD
  } busOp_e;

  typedef enum logic [1:0] {TMR_RST, TMR_PWR, TMR_LOCK} tmrSel_e;

  typedef struct packed {
    logic    latchIn;
    logic    timerLoad;
    tmrSel_e timerSel;
    logic    idxClr;
    logic    idxInc;
    logic    saveTest;
    logic    capData;
    busOp_e  op;
  } ctrlStb_t;

  typedef struct packed {
    logic timerDone;
    logic idxLast;
    logic trimUse;
    logic locked;
    logic diffMode;
  } dpStat_t;

endpackage

// File: rtl/phy_init_dp.sv
module phy_init_dp
  import phy_init_pkg::*;
#(
  parameter int CLKS_PER_US = 50,
  parameter int RST_US      = 100,
  parameter int PWR_US      = 150,
  parameter int LOCK_US     = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctrlStb_t   stb,
  input  logic [7:0] trimByte,
  input  logic       trimValid,
  input  logic       clkSchemeSel,
  input  logic [7:0] regRdata,
  output dpStat_t    stat,
  output logic       regWrite,
  output logic [7:0] regAddr,
  output logic [7:0] regWdata
);

  localparam int RST_CYC  = CLKS_PER_US * RST_US;
  localparam int PWR_CYC  = CLKS_PER_US * PWR_US;
  localparam int LOCK_CYC = CLKS_PER_US * LOCK_US;
  localparam int MAX_A    = (RST_CYC > PWR_CYC) ? RST_CYC : PWR_CYC;
  localparam int MAX_CYC  = (MAX_A > LOCK_CYC) ? MAX_A : LOCK_CYC;
  localparam int TW       = $clog2(MAX_CYC + 1);

  logic [TW-1:0]     timer;
  logic [TBL_IW-1:0] idx;
  logic [7:0]        savedTest;
  logic [7:0]        rdLatch;
  logic [3:0]        trimLo;
  logic              trimUseQ;
  logic              diffQ;
  logic [7:0]        refVal;

  // one shared down-counter serves all three settle phases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (stb.timerLoad) begin
      case (stb.timerSel)
        TMR_RST:  timer <= TW'(RST_CYC - 1);
        TMR_PWR:  timer <= TW'(PWR_CYC - 1);
        default:  timer <= TW'(LOCK_CYC - 1);
      endcase
    end else if (timer != '0) begin
      timer <= timer - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx       <= '0;
      savedTest <= '0;
      rdLatch   <= '0;
      trimLo    <= '0;
      trimUseQ  <= 1'b0;
      diffQ     <= 1'b0;
    end else begin
      if (stb.latchIn) begin
        trimLo   <= trimByte[3:0];
        trimUseQ <= trimValid && (trimByte != 8'h00);
        diffQ    <= !clkSchemeSel;
      end
      if (stb.idxClr)        idx <= '0;
      else if (stb.idxInc)   idx <= idx + TBL_IW'(1);
      if (stb.saveTest)      savedTest <= regRdata;
      if (stb.capData)       rdLatch <= regRdata;
    end
  end

  always_comb begin
    refVal = savedTest;
    refVal[BIT_REFSEL] = !diffQ;
  end

  always_comb begin
    regWrite = 1'b0;
    regAddr  = ADDR_PWRDN;
    regWdata = 8'h00;
    case (stb.op)
      BUS_PD_RD:   regAddr = ADDR_PWRDN;
      BUS_PD_SET:  begin regWrite = 1'b1; regWdata = rdLatch | PWRDN_ALL; end
      BUS_TEST_RD: regAddr = ADDR_PLLTEST;
      BUS_TBL:     begin regWrite = 1'b1; regAddr = tblAddr(idx); regWdata = tblData(idx); end
      BUS_TRIM_RD: regAddr = ADDR_TUNE2;
      BUS_TRIM_WR: begin regWrite = 1'b1; regAddr = ADDR_TUNE2; regWdata = rdLatch | {trimLo, 4'h0}; end
      BUS_PD_CLR:  begin regWrite = 1'b1; regWdata = rdLatch & ~(8'h01 << BIT_PD); end
      BUS_REF_WR:  begin regWrite = 1'b1; regAddr = ADDR_PLLTEST; regWdata = refVal; end
      BUS_REF_RD:  regAddr = ADDR_PLLTEST;
      BUS_STAT_RD: regAddr = ADDR_PLLSTAT;
      default:     regAddr = ADDR_PWRDN;
    endcase
  end

  assign stat.timerDone = (timer == '0);
  assign stat.idxLast   = (idx == TBL_IW'(TBL_LEN - 1));
  assign stat.trimUse   = trimUseQ;
  assign stat.locked    = rdLatch[BIT_LOCK];
  assign stat.diffMode  = diffQ;

endmodule

// File: rtl/phy_init_ctrl.sv
module phy_init_ctrl
  import phy_init_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     exitReq,
  input  logic     regReady,
  input  dpStat_t  stat,
  output ctrlStb_t stb,
  output logic     regValid,
  output logic     phyRst,
  output logic     refClkEn,
  output logic     busy,
  output logic     done,
  output logic     error
);

  typedef enum logic [4:0] {
    S_IDLE, S_RST_HOLD, S_PD_RD, S_PD_SET, S_TEST_RD, S_TBL, S_TRIM_RD,
    S_TRIM_WR, S_PDC_RD, S_PDC_WR, S_PWR_WAIT, S_REF_WR, S_REF_RD,
    S_LOCK_WAIT, S_STAT_RD, S_CHECK, S_ACTIVE, S_EX_RD, S_EX_WR
  } state_e;

  state_e state, nxt;
  logic   fire;

  assign fire = regValid && regReady;

  always_comb begin
    nxt      = state;
    stb      = '0;
    stb.op   = BUS_PD_RD;
    regValid = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        stb.latchIn   = 1'b1;
        stb.timerLoad = 1'b1;
        stb.timerSel  = TMR_RST;
        nxt           = S_RST_HOLD;
      end
      S_RST_HOLD: if (stat.timerDone) nxt = S_PD_RD;
      S_PD_RD: begin
        regValid = 1'b1; stb.op = BUS_PD_RD; stb.capData = fire;
        if (fire) nxt = S_PD_SET;
      end
      S_PD_SET: begin
        regValid = 1'b1; stb.op = BUS_PD_SET;
        if (fire) nxt = S_TEST_RD;
      end
      S_TEST_RD: begin
        regValid = 1'b1; stb.op = BUS_TEST_RD;
        stb.saveTest = fire; stb.idxClr = fire;
        if (fire) nxt = S_TBL;
      end
      S_TBL: begin
        regValid = 1'b1; stb.op = BUS_TBL; stb.idxInc = fire;
        if (fire && stat.idxLast) nxt = stat.trimUse ? S_TRIM_RD : S_PDC_RD;
      end
      S_TRIM_RD: begin
        regValid = 1'b1; stb.op = BUS_TRIM_RD; stb.capData = fire;
        if (fire) nxt = S_TRIM_WR;
      end
      S_TRIM_WR: begin
        regValid = 1'b1; stb.op = BUS_TRIM_WR;
        if (fire) nxt = S_PDC_RD;
      end
      S_PDC_RD: begin
        regValid = 1'b1; stb.op = BUS_PD_RD; stb.capData = fire;
        if (fire) nxt = S_PDC_WR;
      end
      S_PDC_WR: begin
        regValid = 1'b1; stb.op = BUS_PD_CLR;
        if (fire) begin
          stb.timerLoad = 1'b1; stb.timerSel = TMR_PWR; nxt = S_PWR_WAIT;
        end
      end
      S_PWR_WAIT: if (stat.timerDone) nxt = S_REF_WR;
      S_REF_WR: begin
        regValid = 1'b1; stb.op = BUS_REF_WR;
        if (fire) nxt = S_REF_RD;
      end
      S_REF_RD: begin
        regValid = 1'b1; stb.op = BUS_REF_RD;
        if (fire) begin
          stb.timerLoad = 1'b1; stb.timerSel = TMR_LOCK; nxt = S_LOCK_WAIT;
        end
      end
      S_LOCK_WAIT: if (stat.timerDone) nxt = S_STAT_RD;
      S_STAT_RD: begin
        regValid = 1'b1; stb.op = BUS_STAT_RD; stb.capData = fire;
        if (fire) nxt = S_CHECK;
      end
      S_CHECK: nxt = stat.locked ? S_ACTIVE : S_IDLE;
      S_ACTIVE: if (exitReq) nxt = S_EX_RD;
      S_EX_RD: begin
        regValid = 1'b1; stb.op = BUS_PD_RD; stb.capData = fire;
        if (fire) nxt = S_EX_WR;
      end
      S_EX_WR: begin
        regValid = 1'b1; stb.op = BUS_PD_SET;
        if (fire) nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      state <= nxt;
      done  <= (state == S_CHECK) && stat.locked;
      if (state == S_IDLE && start)             error <= 1'b0;
      else if (state == S_CHECK && !stat.locked) error <= 1'b1;
    end
  end

  assign phyRst   = (state == S_IDLE) || (state == S_RST_HOLD);
  assign busy     = !((state == S_IDLE) || (state == S_ACTIVE));
  assign refClkEn = stat.diffMode &&
                    (state inside {S_REF_WR, S_REF_RD, S_LOCK_WAIT, S_STAT_RD,
                                   S_CHECK, S_ACTIVE, S_EX_RD, S_EX_WR});

endmodule

// File: rtl/phy_init_seq.sv
module phy_init_seq
  import phy_init_pkg::*;
#(
  parameter int CLKS_PER_US = 50,
  parameter int RST_US      = 100,
  parameter int PWR_US      = 150,
  parameter int LOCK_US     = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       exitReq,
  input  logic [7:0] trimByte,
  input  logic       trimValid,
  input  logic       clkSchemeSel,
  output logic       regValid,
  output logic       regWrite,
  output logic [7:0] regAddr,
  output logic [7:0] regWdata,
  input  logic       regReady,
  input  logic [7:0] regRdata,
  output logic       phyRst,
  output logic       refClkEn,
  output logic       busy,
  output logic       done,
  output logic       error
);

  ctrlStb_t stb;
  dpStat_t  stat;

  phy_init_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .exitReq(exitReq),
    .regReady(regReady), .stat(stat), .stb(stb), .regValid(regValid),
    .phyRst(phyRst), .refClkEn(refClkEn), .busy(busy), .done(done),
    .error(error)
  );

  phy_init_dp #(
    .CLKS_PER_US(CLKS_PER_US), .RST_US(RST_US),
    .PWR_US(PWR_US), .LOCK_US(LOCK_US)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .trimByte(trimByte),
    .trimValid(trimValid), .clkSchemeSel(clkSchemeSel), .regRdata(regRdata),
    .stat(stat), .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata)
  );

endmodule

// File: rtl/phy_init_chk.sv
module phy_init_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       regValid,
  input logic       regReady,
  input logic       regWrite,
  input logic [7:0] regAddr,
  input logic [7:0] regWdata,
  input logic       phyRst,
  input logic       refClkEn,
  input logic       done,
  input logic       error
);

  a_r11_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    regValid && !regReady |=> regValid && $stable(regAddr) &&
                              $stable(regWrite) && $stable(regWdata));

  a_r1_quiet_in_reset: assert property (@(posedge clk) disable iff (!rstN)
    phyRst |-> !regValid);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_done_not_error: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

  a_r7_refclk_out_of_reset: assert property (@(posedge clk) disable iff (!rstN)
    refClkEn |-> !phyRst);

  a_r10_error_sticky: assert property (@(posedge clk) disable iff (!rstN)
    error && !start |=> error);

endmodule

bind phy_init_seq phy_init_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .regValid(regValid),
  .regReady(regReady), .regWrite(regWrite), .regAddr(regAddr),
  .regWdata(regWdata), .phyRst(phyRst), .refClkEn(refClkEn),
  .done(done), .error(error)
);

// File: tb/sim_phy_init_seq.sv
module sim_phy_init_seq;
  localparam int CPU      = 2;
  localparam int RST_CYC  = CPU * 100;
  localparam int PWR_CYC  = CPU * 150;
  localparam int LOCK_CYC = CPU * 100;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, exitReq = 1'b0;
  logic trimValid = 1'b0, clkSchemeSel = 1'b1;
  logic [7:0] trimByte = 8'h00;
  logic regValid, regWrite, phyRst, refClkEn, busy, done, error;
  logic [7:0] regAddr, regWdata;
  logic regReady = 1'b0;
  logic [7:0] regRdata = 8'h00;

  always #10 clk = ~clk;

  phy_init_seq #(.CLKS_PER_US(CPU)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .exitReq(exitReq),
    .trimByte(trimByte), .trimValid(trimValid), .clkSchemeSel(clkSchemeSel),
    .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regReady(regReady), .regRdata(regRdata),
    .phyRst(phyRst), .refClkEn(refClkEn), .busy(busy), .done(done),
    .error(error)
  );

  int nTests = 0, nFail = 0, cyc = 0;
  logic [7:0] mem [256];
  int logN; logic logW [64]; logic [7:0] logA [64]; logic [7:0] logD [64]; int logT [64];
  int expN; logic expW [64]; logic [7:0] expA [64]; logic [7:0] expD [64]; string expTag [64];
  int holdCnt = 0, doneCnt = 0, resetAccess = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // PHY register model: grants with a random delay, logs each access
  always @(negedge clk) begin
    if (phyRst && busy) holdCnt++;
    if (done) doneCnt++;
    if (regReady) regReady = 1'b0;
    else if (regValid && ($urandom_range(3) != 0)) begin
      if (phyRst) resetAccess++;
      if (logN < 64) begin
        logW[logN] = regWrite; logA[logN] = regAddr;
        logD[logN] = regWdata; logT[logN] = cyc; logN++;
      end
      if (regWrite) mem[regAddr] = regWdata;
      else regRdata = mem[regAddr];
      regReady = 1'b1;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] refAddr(input int i);
    logic [7:0] a [10] = '{8'h80, 8'h84, 8'h88, 8'h8C, 8'h08, 8'h0C, 8'h10, 8'h9C, 8'h1C, 8'h18};
    return a[i];
  endfunction
  function automatic logic [7:0] refData(input int i);
    logic [7:0] d [10] = '{8'hF8, 8'hB3, 8'h83, 8'hC0, 8'h30, 8'h79, 8'h21, 8'h14, 8'h9F, 8'h00};
    return d[i];
  endfunction

  task automatic addExp(input logic w, input logic [7:0] a, input logic [7:0] d, input string t);
    expW[expN] = w; expA[expN] = a; expD[expN] = d; expTag[expN] = t; expN++;
  endtask

  task automatic buildExp(input logic [7:0] i04, input logic [7:0] iB4,
                          input logic [7:0] tr, input bit tv, input bit sch);
    logic [7:0] tune2;
    expN = 0;
    addExp(0, 8'hB4, 0, "R2"); addExp(1, 8'hB4, iB4 | 8'h23, "R2");
    addExp(0, 8'h04, 0, "R3");
    for (int i = 0; i < 10; i++) addExp(1, refAddr(i), refData(i), "R4");
    if (tv && tr != 0) begin
      tune2 = 8'hB3 | (tr << 4);
      addExp(0, 8'h84, 0, "R5"); addExp(1, 8'h84, tune2, "R5");
    end
    addExp(0, 8'hB4, 0, "R6"); addExp(1, 8'hB4, (iB4 | 8'h23) & 8'hFE, "R6");
    addExp(1, 8'h04, sch ? (i04 | 8'h80) : (i04 & 8'h7F), "R7");
    addExp(0, 8'h04, 0, "R7");
    addExp(0, 8'h38, 0, "R8");
  endtask

  task automatic compareLog(input int upTo);
    for (int i = 0; i < upTo; i++) begin
      bit ok;
      ok = (logW[i] == expW[i]) && (logA[i] == expA[i]) && (!expW[i] || logD[i] == expD[i]);
      check(ok, expTag[i], $sformatf("access %0d {write,addr,data}", i),
            {15'd0, logW[i], logA[i], logD[i]}, {15'd0, expW[i], expA[i], expD[i]});
    end
  endtask

  task automatic runOne(input logic [7:0] i04, input logic [7:0] iB4, input logic [7:0] tr,
                        input bit tv, input bit sch, input bit lock, input bit poke);
    bit hadErr;
    int n;
    mem[8'h04] = i04; mem[8'hB4] = iB4;
    mem[8'h38] = lock ? (8'h20 | (8'($urandom) & 8'hDF)) : (8'($urandom) & 8'hDF);
    buildExp(i04, iB4, tr, tv, sch);
    @(negedge clk);
    logN = 0; holdCnt = 0; doneCnt = 0; resetAccess = 0;
    hadErr = error;
    trimByte = tr; trimValid = tv; clkSchemeSel = sch; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (hadErr) check(error == 1'b0, "R10", "error cleared by start", error, 0);
    if (poke) begin
      repeat (RST_CYC + 6) @(negedge clk);
      start = 1'b1; trimValid = 1'b0; clkSchemeSel = !sch;  // must be ignored (R10)
      @(negedge clk); start = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    n = expN;
    check(holdCnt >= RST_CYC, "R1", "reset hold cycles", holdCnt, RST_CYC);
    check(resetAccess == 0, "R1", "accesses during reset", resetAccess, 0);
    check(logN == n, poke ? "R10" : "R5", "access count", logN, n);
    compareLog((logN < n) ? logN : n);
    if (logN >= n) begin
      check(logT[n-3] - logT[n-4] >= PWR_CYC, "R6", "power-up settle gap",
            logT[n-3] - logT[n-4], PWR_CYC);
      check(logT[n-1] - logT[n-2] >= LOCK_CYC, "R7", "lock settle gap",
            logT[n-1] - logT[n-2], LOCK_CYC);
    end
    if (lock) begin
      check(doneCnt == 1, "R8", "done pulses", doneCnt, 1);
      check(!error && !phyRst, "R8", "error/phyRst after lock", {error, phyRst}, 0);
      check(refClkEn == !sch, "R7", "refClkEn while running", refClkEn, !sch);
      repeat (5) @(negedge clk);
      exitReq = 1'b1; @(negedge clk); exitReq = 1'b0;
      while (!phyRst) @(negedge clk);
      @(negedge clk);
      check(logN == n + 2, "R9", "exit access count", logN, n + 2);
      if (logN == n + 2) begin
        check(!logW[n] && logA[n] == 8'hB4, "R9", "exit read",
              {logW[n], logA[n]}, 8'hB4);
        check(logW[n+1] && logA[n+1] == 8'hB4 && logD[n+1] == (iB4 | 8'h23), "R9",
              "exit write", logD[n+1], iB4 | 8'h23);
      end
      check(!refClkEn && phyRst && !busy, "R9", "state after exit",
            {refClkEn, phyRst, busy}, 3'b010);
    end else begin
      check(doneCnt == 0, "R8", "done pulses on lock failure", doneCnt, 0);
      check(error && phyRst && !refClkEn, "R8", "error/phyRst/refClkEn",
            {error, phyRst, refClkEn}, 3'b110);
      repeat (10) @(negedge clk);
      check(error == 1'b1, "R10", "error held", error, 1);
    end
  endtask

  initial begin
    wait (cyc >= 150000);
    nTests++; nFail++;
    $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1));
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    logN = 0;
    repeat (4) @(negedge clk);
    check(phyRst && !refClkEn && !busy && !done && !error && !regValid, "R12",
          "state in reset", {phyRst, refClkEn, busy, done, error, regValid}, 6'b100000);
    rstN = 1'b1;
    @(negedge clk);
    check(phyRst && !refClkEn && !busy && !done && !error && !regValid, "R12",
          "state after reset", {phyRst, refClkEn, busy, done, error, regValid}, 6'b100000);
    runOne(8'h5A, 8'h00, 8'h07, 1, 1, 1, 0);  // single-ended, trim merged
    runOne(8'hC3, 8'h10, 8'h00, 1, 0, 1, 0);  // valid zero trim, differential
    runOne(8'h00, 8'hFF, 8'h0F, 0, 0, 1, 1);  // invalid trim, mid-run start
    runOne(8'h80, 8'h44, 8'h1F, 1, 1, 0, 0);  // truncated trim, lock failure
    runOne(8'h7F, 8'h01, 8'h02, 1, 0, 0, 0);  // differential failure after error
    runOne(8'h11, 8'h22, 8'hA5, 1, 1, 1, 0);  // recovery: error cleared
    for (int k = 0; k < 10; k++)
      runOne(8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
             ($urandom_range(3) != 0), 1'($urandom));
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule